// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block fills a bank of device configuration registers from a small serial EEPROM on a four-wire Microwire link: chip select, serial clock, command/address out and data in. It runs by itself after a hardware reset. The host can also order a fresh load at any later time. While reset is held, the block watches the level on the pad shared with the serial clock. A low level means an external pulldown marks the EEPROM as absent, and the block then skips the automatic load.

Each image byte is fetched with its own READ command, and the bytes are summed modulo 256. The bytes sit in a shadow buffer until the sum has been checked. A sum of FFh commits the whole image to the live registers at once and sets a valid flag. Any other sum, or an absent EEPROM at reset, puts the registers back to their reset defaults and raises a fallback flag, which tells neighbouring logic to use its alternate configuration scheme. While a host-ordered load is running, host bus accesses are not acknowledged.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While `rst_ni` is low, `sk_pad_i` is sampled on every rising clock edge, and `ee_present_o` shows the value taken at the last edge of reset. The pad is not sampled after reset is released.
- R2: If the presence sample was 0, no chip select is raised after reset. `cfg_o` keeps `RESET_CFG`, `fallback_o`=1, `data_valid_o`=0 and `read_pending_o`=0, and `done_o` pulses. All of this happens within 5*CLK_DIV clocks (2.5 serial-clock periods) of the release.
- R3: If the presence sample was 1, the load starts on the first clock after release. `ee_cs_o` and `read_pending_o` go to 1 together.
- R4: Each byte is one frame with `ee_cs_o` high. The frame first shifts out CMD_BITS=3+ADDR_W bits on `ee_di_o`, MSB first: start bit 1, opcode 10, then the byte address. It then shifts in 8 data bits from `ee_do_i`, MSB first, each sampled as `ee_sk_o` rises. `ee_di_o` changes only while `ee_sk_o` is low, and `ee_sk_o` stays low while `ee_cs_o` is low. The frames come in address order 0..NUM_BYTES-1, with exactly CMD_BITS+8 clock pulses per frame.
- R5: Every high and low phase of `ee_sk_o` inside a frame, and the low time from the rise of chip select to the first rising edge, lasts exactly CLK_DIV clocks.
- R6: If the 8-bit sum of all NUM_BYTES bytes is FFh, byte i appears on `cfg_o[8i+7:8i]`, with `data_valid_o`=1 and `fallback_o`=0.
- R7: If the sum is not FFh, `cfg_o` returns to `RESET_CFG` with `data_valid_o`=0 and `fallback_o`=1. The result appears within 2*CLK_DIV clocks (one serial-clock period) after the last chip-select fall.
- R8: `cfg_o` changes only in the cycle in which `done_o` is high, so a partial image is never visible.
- R9: When a load ends, whatever the outcome, `read_pending_o` is 0 and `done_o` is high for exactly one clock.
- R10: A `reload_req_i` pulse while idle starts a full load whatever `ee_present_o` shows, and sets `read_pending_o`=1 on the next clock.
- R11: During a load started by `reload_req_i`, `host_ack_o` stays 0 even when `host_req_i` is 1. At all other times, including a reset-started load, `host_ack_o` equals `host_req_i`. A `reload_req_i` that arrives while a load is running is ignored.
- R12: A load that passes the check after a fallback clears `fallback_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous hardware reset, active low |
| sk_pad_i | input | 1 | Level on the shared serial-clock pad, used for presence |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Command and address bits to the EEPROM |
| ee_do_i | input | 1 | Data bits from the EEPROM |
| reload_req_i | input | 1 | Host request for a fresh load (one-clock pulse) |
| host_req_i | input | 1 | Host bus access attempt |
| host_ack_o | output | 1 | Host access accepted |
| ee_present_o | output | 1 | Presence value latched during reset |
| read_pending_o | output | 1 | A load is in progress |
| data_valid_o | output | 1 | Live registers hold a checked image |
| fallback_o | output | 1 | Alternate configuration mode selected |
| done_o | output | 1 | One-clock pulse at the end of a load |
| cfg_o | output | NUM_BYTES*8 | Live configuration registers |

## Verification
The load is exercised with a series of images driven by a behavioural EEPROM. One image sums to FFh. One is off by one in its last byte. One represents a missing device with the data line stuck high, where the pad pulled high by an LED still reads as present. The series separates a commit from a revert and shows that the presence bit alone does not decide the outcome. The same images are then loaded through host reloads while the presence bit reads absent, which separates a reset-started load from a host-started one. A pulled-low pad at reset tests the aborted path and its timing bound. Throughout, the model checks frame shape, address order and phase lengths, and a monitor flags any change to the registers outside the completion pulse.

// File: rtl/eel_pkg.sv
`timescale 1ns/1ps
package eel_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_CMD,
        ST_DATA,
        ST_GAP,
        ST_CHECK,
        ST_IDLE
    } eel_state_e;

    localparam logic [2:0] MW_READ_HDR = 3'b110;
endpackage

// File: rtl/eel_sk_div.sv
`timescale 1ns/1ps
module eel_sk_div #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!rst_ni || !en_i) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/eel_sum8.sv
`timescale 1ns/1ps
module eel_sum8 #(
    parameter logic [7:0] GOOD_SUM = 8'hFF
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       add_i,
    input  logic [7:0] byte_i,
    output logic       ok_o
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (!rst_ni || clr_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_q + byte_i;
        end
    end

    always_ff @(posedge clk_i) begin
        sum_q <= sum_d;
    end

    assign ok_o = (sum_q == GOOD_SUM);
endmodule

// File: rtl/cfg_eeprom_loader.sv
`timescale 1ns/1ps
module cfg_eeprom_loader
    import eel_pkg::*;
#(
    parameter int NUM_BYTES = 36,
    parameter int ADDR_W    = 6,
    parameter int CLK_DIV   = 4,
    parameter logic [NUM_BYTES*8-1:0] RESET_CFG = {NUM_BYTES{8'h5A}}
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sk_pad_i,
    output logic                   ee_cs_o,
    output logic                   ee_sk_o,
    output logic                   ee_di_o,
    input  logic                   ee_do_i,
    input  logic                   reload_req_i,
    input  logic                   host_req_i,
    output logic                   host_ack_o,
    output logic                   ee_present_o,
    output logic                   read_pending_o,
    output logic                   data_valid_o,
    output logic                   fallback_o,
    output logic                   done_o,
    output logic [NUM_BYTES*8-1:0] cfg_o
);
    localparam int CMD_BITS = 3 + ADDR_W;
    localparam int BCW      = $clog2(CMD_BITS);
    localparam int IDXW     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    typedef struct packed {
        eel_state_e                  st;
        logic                        present;
        logic                        pending;
        logic                        host_blk;
        logic                        valid;
        logic                        fallback;
        logic                        done;
        logic                        cs;
        logic                        sk;
        logic [BCW-1:0]              bit_cnt;
        logic [IDXW-1:0]             idx;
        logic [7:0]                  sr;
        logic [NUM_BYTES-1:0][7:0]   shadow;
        logic [NUM_BYTES*8-1:0]      cfg;
    } regs_t;

    regs_t r_d, r_q;

    logic                tick;
    logic                div_en;
    logic                sum_clr;
    logic                sum_add;
    logic                sum_ok;
    logic [CMD_BITS-1:0] cmd_word;

    assign div_en = (r_q.st == ST_CMD) || (r_q.st == ST_DATA) || (r_q.st == ST_GAP);

    eel_sk_div #(.DIV(CLK_DIV)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (div_en),
        .tick_o (tick)
    );

    eel_sum8 #(.GOOD_SUM(8'hFF)) u_sum (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (sum_clr),
        .add_i  (sum_add),
        .byte_i (r_q.sr),
        .ok_o   (sum_ok)
    );

    assign cmd_word = {MW_READ_HDR, ADDR_W'(r_q.idx)};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        sum_clr  = 1'b0;
        sum_add  = 1'b0;
        if (!rst_ni) begin
            r_d         = '0;
            r_d.st      = ST_BOOT;
            r_d.cfg     = RESET_CFG;
            r_d.present = sk_pad_i;
        end else begin
            unique case (r_q.st)
                ST_BOOT: begin
                    if (r_q.present) begin
                        r_d.st      = ST_CMD;
                        r_d.cs      = 1'b1;
                        r_d.sk      = 1'b0;
                        r_d.bit_cnt = '0;
                        r_d.idx     = '0;
                        r_d.pending = 1'b1;
                        sum_clr     = 1'b1;
                    end else begin
                        r_d.st       = ST_IDLE;
                        r_d.pending  = 1'b0;
                        r_d.valid    = 1'b0;
                        r_d.fallback = 1'b1;
                        r_d.done     = 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (reload_req_i) begin
                        r_d.st       = ST_CMD;
                        r_d.cs       = 1'b1;
                        r_d.sk       = 1'b0;
                        r_d.bit_cnt  = '0;
                        r_d.idx      = '0;
                        r_d.pending  = 1'b1;
                        r_d.host_blk = 1'b1;
                        sum_clr      = 1'b1;
                    end
                end
                ST_CMD: begin
                    if (tick) begin
                        if (!r_q.sk) begin
                            r_d.sk = 1'b1;
                        end else begin
                            r_d.sk = 1'b0;
                            if (r_q.bit_cnt == BCW'(CMD_BITS - 1)) begin
                                r_d.st      = ST_DATA;
                                r_d.bit_cnt = '0;
                            end else begin
                                r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (!r_q.sk) begin
                            r_d.sk = 1'b1;
                            r_d.sr = {r_q.sr[6:0], ee_do_i};
                        end else begin
                            r_d.sk = 1'b0;
                            if (r_q.bit_cnt == BCW'(7)) begin
                                r_d.shadow[r_q.idx] = r_q.sr;
                                sum_add             = 1'b1;
                                r_d.cs              = 1'b0;
                                r_d.bit_cnt         = '0;
                                r_d.st = (r_q.idx == IDXW'(NUM_BYTES - 1)) ? ST_CHECK : ST_GAP;
                            end else begin
                                r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.cs  = 1'b1;
                        r_d.st  = ST_CMD;
                    end
                end
                ST_CHECK: begin
                    if (sum_ok) begin
                        r_d.cfg      = r_q.shadow;
                        r_d.valid    = 1'b1;
                        r_d.fallback = 1'b0;
                    end else begin
                        r_d.cfg      = RESET_CFG;
                        r_d.valid    = 1'b0;
                        r_d.fallback = 1'b1;
                    end
                    r_d.pending  = 1'b0;
                    r_d.host_blk = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.st       = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    always_comb begin
        ee_di_o = 1'b0;
        if (r_q.st == ST_CMD && r_q.cs) begin
            ee_di_o = cmd_word[BCW'(CMD_BITS - 1) - r_q.bit_cnt];
        end
    end

    assign ee_cs_o        = r_q.cs;
    assign ee_sk_o        = r_q.sk;
    assign host_ack_o     = host_req_i && !r_q.host_blk;
    assign ee_present_o   = r_q.present;
    assign read_pending_o = r_q.pending;
    assign data_valid_o   = r_q.valid;
    assign fallback_o     = r_q.fallback;
    assign done_o         = r_q.done;
    assign cfg_o          = r_q.cfg;

    // R4: serial clock idles low outside a frame
    assert_sk_idle_outside_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ee_cs_o |-> !ee_sk_o);

    // R4: outgoing bit only moves during the low phase
    assert_di_moves_when_sk_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ee_di_o) |-> !ee_sk_o);

    // R9: completion strobe lasts one clock
    assert_done_single_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: pending flag is down when the strobe fires
    assert_done_clears_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !read_pending_o);

    // R8: live registers move only with the completion strobe
    assert_cfg_moves_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cfg_o) |-> done_o);

    // R6: a committed image never coexists with fallback
    assert_valid_excludes_fallback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_valid_o |-> !fallback_o);

    // R2: no frame is ever open while fallback is active and idle
    assert_no_frame_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !ee_cs_o);
endmodule

// File: tb/tb_cfg_eeprom_loader.sv
`timescale 1ns/1ps
module tb_cfg_eeprom_loader;
    localparam int NB       = 36;
    localparam int AW       = 6;
    localparam int DIV      = 2;
    localparam int CMD_BITS = 3 + AW;
    localparam logic [NB*8-1:0] DEF = {NB{8'hC3}};

    typedef struct packed {
        logic       reload;
        logic       pin;
        logic [1:0] kind;
        logic       exp_valid;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 2'd0, 1'b1},
        '{1'b0, 1'b1, 2'd1, 1'b0},
        '{1'b0, 1'b1, 2'd2, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b0},
        '{1'b1, 1'b0, 2'd0, 1'b1},
        '{1'b1, 1'b0, 2'd1, 1'b0},
        '{1'b1, 1'b0, 2'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic sk_pad = 1'b1;
    logic ee_cs, ee_sk, ee_di;
    logic ee_do = 1'b0;
    logic reload_req = 1'b0;
    logic host_req = 1'b0;
    logic host_ack, present, pending, valid, fallback, done;
    logic [NB*8-1:0] cfg;

    always #5 clk = ~clk;

    cfg_eeprom_loader #(
        .NUM_BYTES (NB),
        .ADDR_W    (AW),
        .CLK_DIV   (DIV),
        .RESET_CFG (DEF)
    ) dut (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .sk_pad_i       (sk_pad),
        .ee_cs_o        (ee_cs),
        .ee_sk_o        (ee_sk),
        .ee_di_o        (ee_di),
        .ee_do_i        (ee_do),
        .reload_req_i   (reload_req),
        .host_req_i     (host_req),
        .host_ack_o     (host_ack),
        .ee_present_o   (present),
        .read_pending_o (pending),
        .data_valid_o   (valid),
        .fallback_o     (fallback),
        .done_o         (done),
        .cfg_o          (cfg)
    );

    // behavioural EEPROM
    logic [7:0] mem [NB];
    logic       attached = 1'b1;
    int  pulse_n = 0, cs_rises = 0, frame_err = 0, order_err = 0, phase_err = 0;
    logic sk_seen = 1'b0, cs_seen = 1'b0;
    logic [CMD_BITS-1:0] cmd_sh = '0;
    logic [7:0] out_sh = '0;
    time last_evt = 0;

    always begin
        @(ee_cs or ee_sk);
        #1;
        if (ee_sk !== sk_seen) begin
            if ((ee_cs || cs_seen) && (($time - last_evt) != DIV * 10)) phase_err++;
            last_evt = $time;
            if (ee_sk === 1'b1) begin
                if (!ee_cs) frame_err++;
                else if (pulse_n < CMD_BITS) begin
                    cmd_sh = {cmd_sh[CMD_BITS-2:0], ee_di};
                    if (pulse_n == CMD_BITS - 1) begin
                        if (cmd_sh[CMD_BITS-1 -: 3] != 3'b110) frame_err++;
                        if (int'(cmd_sh[AW-1:0]) != (cs_rises - 1) % NB) order_err++;
                        out_sh = attached ? mem[cmd_sh[AW-1:0]] : 8'hFF;
                        ee_do  = out_sh[7];
                    end
                end else begin
                    out_sh = {out_sh[6:0], 1'b1};
                    ee_do  = out_sh[7];
                end
                pulse_n++;
            end
        end
        if (ee_cs === 1'b1 && !cs_seen) begin
            pulse_n = 0;
            cs_rises++;
            last_evt = $time;
        end
        if (ee_cs === 1'b0 && cs_seen && pulse_n != CMD_BITS + 8) frame_err++;
        sk_seen = (ee_sk === 1'b1);
        cs_seen = (ee_cs === 1'b1);
    end

    // R8 monitor: registers change only with the done strobe
    int cfg_err = 0;
    logic [NB*8-1:0] cfg_prev = '0;
    logic rst_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_ni && rst_prev && cfg !== cfg_prev && !done) cfg_err++;
        cfg_prev = cfg;
        rst_prev = rst_ni;
    end

    int n_chk = 0, n_bad = 0;
    logic timed_out = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_ni = 1'b0;
        sk_pad = ~pin;
        repeat (3) @(negedge clk);
        sk_pad = pin;
        repeat (2) @(negedge clk);
        check(present == pin, "R1", "presence latched in reset", 64'(present), 64'(pin));
        rst_ni = 1'b1;
        sk_pad = ~pin;
    endtask

    task automatic wait_done(output int cyc, output int since_fall);
        logic cs_prev;
        cs_prev    = ee_cs;
        cyc        = 0;
        since_fall = -1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cs_prev && !ee_cs) since_fall = 0;
            else if (since_fall >= 0) since_fall++;
            cs_prev = ee_cs;
        end
    endtask

    task automatic build_image(input int seed, input logic [1:0] kind);
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < NB - 1; i++) begin
            mem[i] = 8'((i * 13) + (seed * 29) + 1);
            s = s + mem[i];
        end
        mem[NB-1] = 8'hFF - s + ((kind == 2'd1) ? 8'd1 : 8'd0);
        attached  = (kind != 2'd2);
    endtask

    task automatic run_all();
        int cyc, since_fall, rises0;
        logic [NB*8-1:0] exp_cfg;

        // reset state
        rst_ni = 1'b0;
        sk_pad = 1'b1;
        repeat (4) @(negedge clk);
        check(ee_cs == 1'b0, "R4", "cs in reset", 64'(ee_cs), 64'd0);
        check(pending == 1'b0 && done == 1'b0, "R9", "pending/done in reset",
              64'({pending, done}), 64'd0);
        check(valid == 1'b0 && fallback == 1'b0, "R6", "valid/fallback in reset",
              64'({valid, fallback}), 64'd0);
        check(cfg == DEF, "R7", "cfg defaults in reset", cfg[63:0], DEF[63:0]);

        for (int v = 0; v < NV; v++) begin
            build_image(v, VEC[v].kind);
            for (int i = 0; i < NB; i++) exp_cfg[i*8 +: 8] = mem[i];
            if (!VEC[v].exp_valid) exp_cfg = DEF;
            rises0 = cs_rises;
            if (!VEC[v].reload) begin
                do_reset(VEC[v].pin);
                if (!VEC[v].pin) begin
                    wait_done(cyc, since_fall);
                    check(cyc <= 5 * DIV, "R2", "absent fallback latency", 64'(cyc), 64'(5 * DIV));
                    check(cs_rises == rises0, "R2", "no frame when absent",
                          64'(cs_rises - rises0), 64'd0);
                    check(pending == 1'b0, "R2", "pending when absent", 64'(pending), 64'd0);
                end else begin
                    @(negedge clk);
                    check(ee_cs == 1'b1 && pending == 1'b1, "R3", "auto load start",
                          64'({ee_cs, pending}), 64'd3);
                    host_req = 1'b1;
                    #1;
                    check(host_ack == 1'b1, "R11", "ack during reset load", 64'(host_ack), 64'd1);
                    host_req = 1'b0;
                    wait_done(cyc, since_fall);
                end
            end else begin
                @(negedge clk);
                reload_req = 1'b1;
                @(negedge clk);
                reload_req = 1'b0;
                check(pending == 1'b1, "R10", "reload sets pending", 64'(pending), 64'd1);
                host_req = 1'b1;
                #1;
                check(host_ack == 1'b0, "R11", "ack blocked in reload", 64'(host_ack), 64'd0);
                host_req = 1'b0;
                wait_done(cyc, since_fall);
            end
            if (VEC[v].reload || VEC[v].pin) begin
                check(cs_rises - rises0 == NB, "R10", "frames per load",
                      64'(cs_rises - rises0), 64'(NB));
                if (!VEC[v].exp_valid)
                    check(since_fall >= 0 && since_fall <= 2 * DIV, "R7", "revert latency",
                          64'(since_fall), 64'(2 * DIV));
            end
            check(done == 1'b1 && pending == 1'b0, "R9", "done with pending clear",
                  64'({done, pending}), 64'd2);
            check(valid == VEC[v].exp_valid, "R6", "valid flag", 64'(valid), 64'(VEC[v].exp_valid));
            check(fallback == !VEC[v].exp_valid, VEC[v].reload ? "R12" : "R7", "fallback flag",
                  64'(fallback), 64'(!VEC[v].exp_valid));
            check(cfg == exp_cfg, VEC[v].exp_valid ? "R6" : "R7", "cfg content",
                  cfg[63:0], exp_cfg[63:0]);
            @(negedge clk);
            check(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
            host_req = 1'b1;
            #1;
            check(host_ack == 1'b1, "R11", "ack when idle", 64'(host_ack), 64'd1);
            host_req = 1'b0;
        end

        // reload ignored while a load runs
        build_image(11, 2'd0);
        rises0 = cs_rises;
        @(negedge clk);
        reload_req = 1'b1;
        @(negedge clk);
        reload_req = 1'b0;
        repeat (200) @(negedge clk);
        reload_req = 1'b1;
        @(negedge clk);
        reload_req = 1'b0;
        wait_done(cyc, since_fall);
        repeat (20) @(negedge clk);
        check(cs_rises - rises0 == NB, "R11", "reload during load ignored",
              64'(cs_rises - rises0), 64'(NB));
        check(pending == 1'b0 && ee_cs == 1'b0, "R11", "idle after ignored reload",
              64'({pending, ee_cs}), 64'd0);

        check(frame_err == 0, "R4", "frame shape errors", 64'(frame_err), 64'd0);
        check(order_err == 0, "R4", "address order errors", 64'(order_err), 64'd0);
        check(phase_err == 0, "R5", "serial clock phase errors", 64'(phase_err), 64'd0);
        check(cfg_err == 0, "R8", "cfg changes outside done", 64'(cfg_err), 64'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) check(1'b0, "R9", "watchdog expired", 64'd1, 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule